// File: doc/BRIEF.md
# Saturating Rounding Doubling Multiply-Accumulate Lanes

This block is a packed-vector unit for signed fixed-point arithmetic. Each lane takes a multiplicand pair and the lane's current destination value, which serves as the accumulator. It forms the destination scaled up by one lane width, adds or subtracts twice the product, adds a half-unit rounding term and keeps the upper half. That value is clipped to the signed range of the lane. The lanes can be 16 bits or 32 bits wide, and the result replaces the destination.

One registered stage sits between a valid-in strobe and a valid-out strobe. An operation-size input, given in 64-bit chunks, limits the part of the vector that takes part. Chunks above it come out as zero and never count as saturating. A sticky flag records that some active lane was clipped. It stays set until a synchronous clear input is driven.

Top module: `sqrd_mac_top`

## Requirements
- R1: With `wideLanes`=0 and `subMode`=0, each 16-bit lane gives floor(((acc << 15) + a*b + 2^14) / 2^15), where a, b and acc are signed.
- R2: With `subMode`=1, the product is subtracted instead: floor(((acc << 15) - a*b + 2^14) / 2^15) for 16-bit lanes, and the same form for 32-bit lanes.
- R3: With `wideLanes`=1, each 32-bit lane gives floor(((acc << 31) ± a*b + 2^30) / 2^31), formed without loss of precision.
- R4: When the shifted value does not fit the lane, the lane gives the most positive value (0x7FFF or 0x7FFFFFFF) for a positive overflow and the most negative value (0x8000 or 0x80000000) for a negative overflow.
- R5: `satSticky` goes to 1 on the edge that captures an operation in which any active lane clipped. Operations without clipping leave it unchanged.
- R6: `satClear`=1 at an edge clears `satSticky`, unless the same edge captures a clipping operation. In that case the flag ends up at 1.
- R7: Lane i occupies bits [16i+15:16i] for 16-bit lanes and bits [32i+31:32i] for 32-bit lanes. Each lane is computed on its own.
- R8: 64-bit chunk k of the result is zero when k >= `activeChunks`, and its lanes never set the flag. Values above VEC_BYTES/8 act as the full vector.
- R9: `outValid` is `inValid` delayed by one clock. `result` changes only on an edge where `inValid`=1.
- R10: After reset, `outValid`, `result` and `satSticky` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Operands valid; captured on this edge |
| subMode | input | 1 | 0 adds the doubled product, 1 subtracts it |
| wideLanes | input | 1 | 0 selects 16-bit lanes, 1 selects 32-bit lanes |
| activeChunks | input | CHUNK_W (2) | Active size in 64-bit chunks |
| satClear | input | 1 | Synchronous clear of the sticky flag |
| srcA | input | VEC_BYTES*8 (128) | First multiplicand vector |
| srcB | input | VEC_BYTES*8 (128) | Second multiplicand vector |
| accIn | input | VEC_BYTES*8 (128) | Accumulator (prior destination) vector |
| outValid | output | 1 | Result valid |
| result | output | VEC_BYTES*8 (128) | Destination vector |
| satSticky | output | 1 | Sticky cumulative-saturation flag |

## Verification
The bench aims at the extremes of the product. Both multiplicands at the most negative value give a product that looks representable but overflows once doubled, so a design that skips the clip would return 0x8000 where 0x7FFF is correct. Accumulators at each end of the range, combined with add and subtract, check that the clip goes toward the sign of the true result; a design that clips from a truncated sign bit picks the wrong end. Reduced operation sizes with clipping inputs placed in the tail check that the tail comes out zero and leaves the flag alone. A simultaneous clear and clip checks that the set takes priority, and distinct per-lane values catch swapped halves.

// File: rtl/sqrd_pkg.sv
package sqrd_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;   // load the result register on this edge
    logic negate;    // subtract the doubled product
    logic wide;      // 32-bit lanes
  } sqrd_strobe_t;

  // One lane outcome: clip indication plus value (16-bit lanes use the low half).
  typedef struct packed {
    logic        sat;
    logic [31:0] val;
  } lane_res_t;

  // 16-bit lane: ((c << 15) +/- a*b + 2^14) >>> 15 with signed clipping.
  function automatic lane_res_t half_op(logic signed [15:0] a, logic signed [15:0] b,
                                        logic signed [15:0] c, logic neg);
    logic signed [33:0] prod;
    logic signed [33:0] sum;
    logic signed [33:0] sh;
    lane_res_t r;
    prod = 34'(a) * 34'(b);
    sum  = 34'(c) <<< 15;
    sum  = neg ? (sum - prod) : (sum + prod);
    sum  = sum + 34'sd16384;
    sh   = sum >>> 15;
    r.sat = (sh[33:15] != {19{sh[15]}});
    if (r.sat) r.val = {16'h0, (sh[33] ? 16'h8000 : 16'h7FFF)};
    else       r.val = {16'h0, sh[15:0]};
    return r;
  endfunction

  // 32-bit lane: ((c << 31) +/- a*b + 2^30) >>> 31 with signed clipping.
  function automatic lane_res_t word_op(logic signed [31:0] a, logic signed [31:0] b,
                                        logic signed [31:0] c, logic neg);
    logic signed [65:0] prod;
    logic signed [65:0] sum;
    logic signed [65:0] sh;
    lane_res_t r;
    prod = 66'(a) * 66'(b);
    sum  = 66'(c) <<< 31;
    sum  = neg ? (sum - prod) : (sum + prod);
    sum  = sum + 66'sd1073741824;
    sh   = sum >>> 31;
    r.sat = (sh[65:31] != {35{sh[31]}});
    if (r.sat) r.val = sh[65] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    else       r.val = sh[31:0];
    return r;
  endfunction

endpackage

// File: rtl/sqrd_ctrl.sv
module sqrd_ctrl
  import sqrd_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic         subMode,
  input  logic         wideLanes,
  input  logic         satClear,
  input  logic         satAny,
  output sqrd_strobe_t strobe,
  output logic         outValid,
  output logic         satSticky
);

  always_comb begin
    strobe.capture = inValid;
    strobe.negate  = subMode;
    strobe.wide    = wideLanes;
  end

  logic setSat;
  assign setSat = inValid & satAny;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      satSticky <= 1'b0;
    end else begin
      outValid  <= inValid;
      satSticky <= (satSticky & ~satClear) | setSat;
    end
  end

  AST_SAT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && satAny |=> satSticky); // R5
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    satSticky && !satClear |=> satSticky); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    satClear && !(inValid && satAny) |=> !satSticky); // R6
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid); // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid); // R9

endmodule

// File: rtl/sqrd_datapath.sv
module sqrd_datapath
  import sqrd_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  parameter int CHUNK_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  sqrd_strobe_t             strobe,
  input  logic [CHUNK_W-1:0]       activeChunks,
  input  logic [VEC_BYTES*8-1:0]   srcA,
  input  logic [VEC_BYTES*8-1:0]   srcB,
  input  logic [VEC_BYTES*8-1:0]   accIn,
  output logic                     satAny,
  output logic [VEC_BYTES*8-1:0]   result
);

  localparam int VEC_BITS = VEC_BYTES * 8;
  localparam int WORDS    = VEC_BITS / 32;
  localparam int CHUNKS   = VEC_BYTES / 8;

  logic [CHUNKS-1:0]   chunkOn;
  logic [WORDS-1:0]    wordSat;
  logic [VEC_BITS-1:0] nextRes;

  for (genvar k = 0; k < CHUNKS; k++) begin : g_chunk
    assign chunkOn[k] = (int'(activeChunks) > k);
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    lane_res_t loHalf, hiHalf, full;
    logic [31:0] wordVal;
    logic        wordClip;
    always_comb begin
      loHalf = half_op(srcA[32*w +: 16], srcB[32*w +: 16], accIn[32*w +: 16], strobe.negate);
      hiHalf = half_op(srcA[32*w+16 +: 16], srcB[32*w+16 +: 16], accIn[32*w+16 +: 16],
                       strobe.negate);
      full   = word_op(srcA[32*w +: 32], srcB[32*w +: 32], accIn[32*w +: 32], strobe.negate);
      if (strobe.wide) begin
        wordVal  = full.val;
        wordClip = full.sat;
      end else begin
        wordVal  = {hiHalf.val[15:0], loHalf.val[15:0]};
        wordClip = loHalf.sat | hiHalf.sat;
      end
    end
    assign nextRes[32*w +: 32] = chunkOn[w/2] ? wordVal : 32'h0;
    assign wordSat[w]          = chunkOn[w/2] & wordClip;
  end

  assign satAny = |wordSat;

  always_ff @(posedge clk) begin
    if (!rst_n)              result <= '0;
    else if (strobe.capture) result <= nextRes;
  end

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> $stable(result)); // R9

  for (genvar k = 0; k < CHUNKS; k++) begin : g_tail_chk
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.capture && (int'(activeChunks) <= k) |=> (result[64*k +: 64] == 64'h0)); // R8
  end

endmodule

// File: rtl/sqrd_mac_top.sv
module sqrd_mac_top
  import sqrd_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  localparam int VEC_BITS = VEC_BYTES * 8,
  localparam int CHUNK_W  = $clog2(VEC_BYTES / 8 + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic                subMode,
  input  logic                wideLanes,
  input  logic [CHUNK_W-1:0]  activeChunks,
  input  logic                satClear,
  input  logic [VEC_BITS-1:0] srcA,
  input  logic [VEC_BITS-1:0] srcB,
  input  logic [VEC_BITS-1:0] accIn,
  output logic                outValid,
  output logic [VEC_BITS-1:0] result,
  output logic                satSticky
);

  sqrd_strobe_t strobe;
  logic         satAny;

  sqrd_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .subMode(subMode),
    .wideLanes(wideLanes), .satClear(satClear), .satAny(satAny),
    .strobe(strobe), .outValid(outValid), .satSticky(satSticky)
  );

  sqrd_datapath #(.VEC_BYTES(VEC_BYTES), .CHUNK_W(CHUNK_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .activeChunks(activeChunks),
    .srcA(srcA), .srcB(srcB), .accIn(accIn), .satAny(satAny), .result(result)
  );

endmodule

// File: tb/sqrd_mac_top_tb.sv
module sqrd_mac_top_tb_top;

  localparam int VB = 128;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic          subMode = 1'b0;
  logic          wideLanes = 1'b0;
  logic [CW-1:0] activeChunks = '0;
  logic          satClear = 1'b0;
  logic [VB-1:0] srcA = '0, srcB = '0, accIn = '0;
  logic          outValid;
  logic [VB-1:0] result;
  logic          satSticky;

  always #5 clk = ~clk;

  sqrd_mac_top #(.VEC_BYTES(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .subMode(subMode),
    .wideLanes(wideLanes), .activeChunks(activeChunks), .satClear(satClear),
    .srcA(srcA), .srcB(srcB), .accIn(accIn), .outValid(outValid),
    .result(result), .satSticky(satSticky)
  );

  typedef struct { logic [VB-1:0] res; logic flg; string tag; } exp_t;
  exp_t          sb[$];
  int            checks = 0;
  int            errors = 0;
  logic          modelFlag = 1'b0;
  logic [VB-1:0] lastRes = '0;
  bit            done = 1'b0;

  task automatic check(bit ok, string tag, logic [VB-1:0] act, logic [VB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: high half of (c << W) +/- 2ab + 2^(W-1), clipped.
  function automatic logic [31:0] ref_lane(logic signed [31:0] a, logic signed [31:0] b,
                                           logic signed [31:0] c, bit neg, bit wide,
                                           output bit clip);
    logic signed [71:0] t, lo, hi;
    int w;
    w = wide ? 32 : 16;
    t = (72'(c) <<< w) + 72'sd1 <<< (w - 1);
    t = (72'(c) <<< w) + (72'sd1 <<< (w - 1));
    if (neg) t = t - 72'sd2 * 72'(a) * 72'(b);
    else     t = t + 72'sd2 * 72'(a) * 72'(b);
    t  = t >>> w;
    hi = (72'sd1 <<< (w - 1)) - 72'sd1;
    lo = -(72'sd1 <<< (w - 1));
    clip = 1'b0;
    if (t > hi)      begin t = hi; clip = 1'b1; end
    else if (t < lo) begin t = lo; clip = 1'b1; end
    return t[31:0];
  endfunction

  function automatic logic [VB-1:0] ref_vec(logic [VB-1:0] a, logic [VB-1:0] b,
                                            logic [VB-1:0] c, bit neg, bit wide,
                                            int chunks, output bit anyClip);
    logic [VB-1:0] r;
    bit clip;
    r = '0;
    anyClip = 1'b0;
    if (wide) begin
      for (int i = 0; i < VB / 32; i++) begin
        if (i / 2 < chunks) begin
          r[32*i +: 32] = ref_lane(a[32*i +: 32], b[32*i +: 32], c[32*i +: 32], neg, 1'b1, clip);
          anyClip |= clip;
        end
      end
    end else begin
      for (int i = 0; i < VB / 16; i++) begin
        if (i / 4 < chunks) begin
          r[16*i +: 16] = ref_lane(32'(signed'(a[16*i +: 16])), 32'(signed'(b[16*i +: 16])),
                                   32'(signed'(c[16*i +: 16])), neg, 1'b0, clip);
          anyClip |= clip;
        end
      end
    end
    return r;
  endfunction

  task automatic run_op(logic [VB-1:0] a, logic [VB-1:0] b, logic [VB-1:0] c, bit neg,
                        bit wide, int chunks, bit clr, string tag);
    exp_t e;
    bit clip;
    e.res = ref_vec(a, b, c, neg, wide, chunks, clip);
    modelFlag = (modelFlag & ~clr) | clip;
    e.flg = modelFlag;
    e.tag = tag;
    lastRes = e.res;
    @(negedge clk);
    sb.push_back(e);
    inValid = 1'b1; subMode = neg; wideLanes = wide;
    activeChunks = CW'(chunks); satClear = clr;
    srcA = a; srcB = b; accIn = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; satClear = 1'b0;
      srcA = {4{$urandom}}; srcB = {4{$urandom}}; accIn = {4{$urandom}};
    end
  endtask

  // Monitor: compare each produced result against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected outValid", {127'h0, outValid}, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result === e.res, e.tag, result, e.res);
        check(satSticky === e.flg, {"R5 flag after ", e.tag}, {127'h0, satSticky},
              {127'h0, e.flg});
      end
    end
  end

  function automatic logic [VB-1:0] rep16(logic [15:0] v);
    return {8{v}};
  endfunction
  function automatic logic [VB-1:0] rep32(logic [31:0] v);
    return {4{v}};
  endfunction
  function automatic logic [VB-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R10 reset outValid", {127'h0, outValid}, '0);
    check(result === '0, "R10 reset result", result, '0);
    check(satSticky === 1'b0, "R10 reset flag", {127'h0, satSticky}, '0);
    rst_n = 1'b1;

    // R1 plain accumulate, no clipping
    run_op(rep16(16'h4000), rep16(16'h2000), rep16(16'h0100), 0, 0, 2, 0, "R1 acc16");
    // R7 distinct per-lane values
    run_op({16'h0008, 16'h0007, 16'h0006, 16'h0005, 16'h0004, 16'h0003, 16'h0002, 16'h0001},
           rep16(16'h4000), {16'h7000, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'hF000},
           0, 0, 2, 0, "R7 lane order 16");
    run_op({32'h0000_0004, 32'h0000_0003, 32'h0000_0002, 32'h0000_0001}, rep32(32'h4000_0000),
           {32'h1000_0000, 32'h0, 32'h0, 32'hF000_0000}, 0, 1, 2, 0, "R7 lane order 32");
    // R2 subtract without clipping
    run_op(rep16(16'h1234), rep16(16'hF321), rep16(16'h0F00), 1, 0, 2, 0, "R2 sub16");
    // R4 both multiplicands most negative, acc 0: clip to 0x7FFF
    run_op(rep16(16'h8000), rep16(16'h8000), rep16(16'h0000), 0, 0, 2, 0, "R4 min*min 16");
    // R6 clear together with a clean op: flag drops; min*min with acc min gives 0
    run_op(rep16(16'h8000), rep16(16'h8000), rep16(16'h8000), 0, 0, 2, 1, "R6 clear clean op");
    // R4 positive extreme accumulator
    run_op(rep16(16'h7FFF), rep16(16'h7FFF), rep16(16'h7FFF), 0, 0, 2, 0, "R4 pos clip 16");
    // R6 clear with a clipping op: set wins
    run_op(rep16(16'h7FFF), rep16(16'h7FFF), rep16(16'h8000), 1, 0, 2, 1, "R6 set beats clear");
    run_op(rep16(16'h0), rep16(16'h0), rep16(16'h0), 0, 0, 2, 1, "R6 clear");
    // R3 32-bit lanes
    run_op(rep32(32'h4000_0000), rep32(32'h2000_0000), rep32(32'h0100_0000), 0, 1, 2, 0,
           "R3 acc32");
    run_op(rep32(32'h8000_0000), rep32(32'h8000_0000), rep32(32'h0), 0, 1, 2, 1,
           "R3 R4 min*min 32");
    run_op(rep32(32'h7FFF_FFFF), rep32(32'h7FFF_FFFF), rep32(32'h8000_0000), 1, 1, 2, 1,
           "R2 R4 neg clip 32");
    // R8 clipping inputs only in the tail chunk: tail zero, flag untouched
    run_op({{4{16'h8000}}, {4{16'h1111}}}, {{4{16'h8000}}, {4{16'h2222}}}, '0, 0, 0, 1, 1,
           "R8 tail ignored");
    run_op(rep16(16'h8000), rep16(16'h8000), '0, 0, 0, 0, 0, "R8 zero size");
    run_op(rep16(16'h8000), rep16(16'h8000), '0, 0, 0, 3, 0, "R8 oversize acts full");

    // R9 hold: no capture for a while, result unchanged and no valid
    idle(4);
    check(outValid === 1'b0, "R9 idle outValid", {127'h0, outValid}, '0);
    check(result === lastRes, "R9 hold result", result, lastRes);

    // R6 clear while idle
    @(negedge clk);
    satClear = 1'b1;
    modelFlag = 1'b0;
    @(negedge clk);
    satClear = 1'b0;
    check(satSticky === 1'b0, "R6 idle clear", {127'h0, satSticky}, '0);
    check(result === lastRes, "R9 clear keeps result", result, lastRes);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      bit w, n, c;
      int ch;
      w  = $urandom_range(0, 1);
      n  = $urandom_range(0, 1);
      c  = ($urandom_range(0, 7) == 0);
      ch = $urandom_range(0, 3);
      run_op(rnd(), rnd(), rnd(), n, w, ch, c, w ? "R3 random" : (n ? "R2 random" : "R1 random"));
      if ($urandom_range(0, 5) == 0) idle(1);
    end
    idle(4);
    check(sb.size() == 0, "R9 all results seen", VB'(sb.size()), '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule